// File: doc/BRIEF.md
# Complementary PWM Leg Generator with Dead Band

This block drives the two switches of one inverter leg. A carrier counter runs over a programmable range in one of three shapes: a rising sawtooth, a falling sawtooth, or a triangle. A duty value is latched once per carrier period, and the primary output is high while the carrier lies below that value. The complementary output follows the inverse level. At every change of level, both outputs are held low for a programmable number of clock cycles, so that the two switches are never on together.

The block also gives a one-cycle trigger, placed either at the middle or at the end of each carrier period, for starting an ADC conversion in step with the switching. The carrier range and shape are taken from their inputs only as one period closes, so they cannot cut a pulse short. The instant at which the duty value is latched is selectable in the same way as the trigger position.

Top module: `pwm_leg_top`

## Requirements
- R1: The carrier follows `mode_sel` with the active maximum M. Code 0 (and the spare code 3) counts 0,1,…,M and repeats. Code 1 counts M,M−1,…,0 and repeats. Code 2 counts 0,1,…,M,M−1,…,1 and repeats, a period of 2M cycles (one cycle when M is 0). The carrier never exceeds M.
- R2: `period_max` and `mode_sel` are taken into use only in the last cycle of a period. The next cycle starts the new period at 0 (codes 0, 2 and 3) or at the new maximum (code 1).
- R3: The period end is its last cycle. The period middle is the cycle where the carrier equals M shifted right by one (codes 0, 1 and 3), or the peak cycle where it equals M (code 2). `adc_start` is high in exactly the middle cycles when `trig_mid` is 1, and in exactly the end cycles when it is 0.
- R4: The compare value loads `duty` at the middle cycle when `latch_mid` is 1, or at the end cycle when it is 0. It holds in every other cycle and takes effect from the following cycle.
- R5: The wanted level is 1 when carrier < compare value. It reaches the outputs one cycle later, with no dead band pending. A duty of 0 keeps `out_hi` low. A duty above M keeps it high for the whole period.
- R6: When the wanted level changes, both outputs are low for `dead_cycles` cycles (the value sampled at the change). After that, the output of the new level goes high. With a dead time of 0 the outputs swap at once.
- R7: A level that lasts `dead_cycles` cycles or fewer never raises its output. A level lasting L cycles raises it for L − `dead_cycles` cycles.
- R8: `out_hi` and `out_lo` are never high together.
- R9: After reset: carrier 0, M 0, compare 0, wanted level low, no dead band pending. So `out_hi` is 0 and `out_lo` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| period_max | input | CNT_W | Carrier maximum for the next period |
| mode_sel | input | 2 | Carrier shape for the next period (0 rise, 1 fall, 2 triangle, 3 as 0) |
| duty | input | CNT_W | Duty compare value |
| latch_mid | input | 1 | 1: latch duty at period middle, 0: at period end |
| trig_mid | input | 1 | 1: trigger at period middle, 0: at period end |
| dead_cycles | input | DT_W | Dead band length in clock cycles |
| carrier | output | CNT_W | Current carrier value |
| out_hi | output | 1 | Primary switch drive |
| out_lo | output | 1 | Complementary switch drive |
| adc_start | output | 1 | One-cycle conversion trigger |

## Verification
The bench builds the block with a 4-bit carrier and a 3-bit dead-band counter. This makes it practical to sweep every maximum from 0 to 15 under all four mode codes, both latch points and both trigger points. Dead times of 0, 1, 2 and 5 cycles are crossed with that sweep. The duty input changes every cycle and regularly hits 0 and full scale. As a result, pulses shorter than, equal to and longer than the dead time all occur, and configuration changes land at arbitrary points inside a period.

// File: rtl/pwm_leg_pkg.sv
package pwm_leg_pkg;
  typedef enum logic [1:0] {
    CM_RISE = 2'd0,
    CM_FALL = 2'd1,
    CM_TRI  = 2'd2,
    CM_SPARE = 2'd3
  } car_mode_e;
endpackage

// File: rtl/pwm_carrier.sv
module pwm_carrier #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cfg_max,
  input  logic [1:0]       cfg_mode,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] max_o,
  output logic [1:0]       mode_o,
  output logic             mid_o,
  output logic             end_o
);
  import pwm_leg_pkg::*;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, max_q;
  car_mode_e        mode_q;
  logic             fall_q;   // triangle is on its falling half

  function automatic logic [CNT_W-1:0] half_of(input logic [CNT_W-1:0] m);
    return m >> 1;
  endfunction

  function automatic logic [CNT_W-1:0] start_of(input car_mode_e md,
                                                input logic [CNT_W-1:0] m);
    return (md == CM_FALL) ? m : '0;
  endfunction

  always_comb begin
    unique case (mode_q)
      CM_FALL: begin
        end_o = (cnt_q == '0);
        mid_o = (cnt_q == half_of(max_q));
      end
      CM_TRI: begin
        end_o = fall_q ? (cnt_q == ONE) : ((max_q <= ONE) && (cnt_q == max_q));
        mid_o = !fall_q && (cnt_q == max_q);
      end
      default: begin
        end_o = (cnt_q == max_q);
        mid_o = (cnt_q == half_of(max_q));
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      max_q  <= '0;
      mode_q <= CM_RISE;
      fall_q <= 1'b0;
    end else if (end_o) begin
      max_q  <= cfg_max;
      mode_q <= car_mode_e'(cfg_mode);
      fall_q <= 1'b0;
      cnt_q  <= start_of(car_mode_e'(cfg_mode), cfg_max);
    end else begin
      unique case (mode_q)
        CM_FALL: cnt_q <= cnt_q - ONE;
        CM_TRI: begin
          if (!fall_q && (cnt_q == max_q)) begin
            fall_q <= 1'b1;
            cnt_q  <= cnt_q - ONE;
          end else if (fall_q) begin
            cnt_q  <= cnt_q - ONE;
          end else begin
            cnt_q  <= cnt_q + ONE;
          end
        end
        default: cnt_q <= cnt_q + ONE;
      endcase
    end
  end

  assign cnt_o  = cnt_q;
  assign max_o  = max_q;
  assign mode_o = mode_q;
endmodule

// File: rtl/pwm_compare.sv
module pwm_compare #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] duty,
  input  logic [CNT_W-1:0] carrier,
  output logic [CNT_W-1:0] cmp_o,
  output logic             want_o
);
  logic [CNT_W-1:0] cmp_q;

  function automatic logic below(input logic [CNT_W-1:0] c,
                                 input logic [CNT_W-1:0] t);
    return c < t;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cmp_q <= '0;
    else if (load) cmp_q <= duty;
  end

  assign cmp_o  = cmp_q;
  assign want_o = below(carrier, cmp_q);
endmodule

// File: rtl/pwm_deadband.sv
module pwm_deadband #(
  parameter int DT_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            want,
  input  logic [DT_W-1:0] gap,
  output logic            drv_hi,
  output logic            drv_lo,
  output logic            flip_o
);
  localparam logic [DT_W-1:0] DT_ONE = DT_W'(1);

  logic            lvl_q;
  logic [DT_W-1:0] wait_q;
  logic            settled;

  assign flip_o  = want ^ lvl_q;
  assign settled = (wait_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q  <= 1'b0;
      wait_q <= '0;
    end else if (flip_o) begin
      lvl_q  <= want;
      wait_q <= gap;
    end else if (!settled) begin
      wait_q <= wait_q - DT_ONE;
    end
  end

  assign drv_hi = lvl_q && settled;
  assign drv_lo = !lvl_q && settled;
endmodule

// File: rtl/pwm_leg_top.sv
module pwm_leg_top #(
  parameter int CNT_W = 8,
  parameter int DT_W  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] period_max,
  input  logic [1:0]       mode_sel,
  input  logic [CNT_W-1:0] duty,
  input  logic             latch_mid,
  input  logic             trig_mid,
  input  logic [DT_W-1:0]  dead_cycles,
  output logic [CNT_W-1:0] carrier,
  output logic             out_hi,
  output logic             out_lo,
  output logic             adc_start
);
  logic [CNT_W-1:0] act_max, cmp_val;
  logic [1:0]       act_mode;
  logic             mid_evt, end_evt, latch_evt, want_lvl, edge_evt;

  pwm_carrier #(.CNT_W(CNT_W)) u_car (
    .clk(clk), .rst_n(rst_n), .cfg_max(period_max), .cfg_mode(mode_sel),
    .cnt_o(carrier), .max_o(act_max), .mode_o(act_mode),
    .mid_o(mid_evt), .end_o(end_evt)
  );

  assign latch_evt = latch_mid ? mid_evt : end_evt;
  assign adc_start = trig_mid ? mid_evt : end_evt;

  pwm_compare #(.CNT_W(CNT_W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .load(latch_evt), .duty(duty),
    .carrier(carrier), .cmp_o(cmp_val), .want_o(want_lvl)
  );

  pwm_deadband #(.DT_W(DT_W)) u_db (
    .clk(clk), .rst_n(rst_n), .want(want_lvl), .gap(dead_cycles),
    .drv_hi(out_hi), .drv_lo(out_lo), .flip_o(edge_evt)
  );
endmodule

// File: rtl/pwm_leg_chk.sv
module pwm_leg_chk #(
  parameter int CNT_W = 8,
  parameter int DT_W  = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             out_hi,
  input logic             out_lo,
  input logic             edge_evt,
  input logic [DT_W-1:0]  dead_cycles,
  input logic             end_evt,
  input logic             mid_evt,
  input logic             latch_mid,
  input logic [CNT_W-1:0] act_max,
  input logic [1:0]       act_mode,
  input logic [CNT_W-1:0] cmp_val,
  input logic [CNT_W-1:0] carrier
);
  // R8
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_hi && out_lo));

  // R6
  dead_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_evt && (dead_cycles != '0)) |=> (!out_hi && !out_lo));

  // R2
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !end_evt |=> ($stable(act_max) && $stable(act_mode)));

  // R4
  duty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(latch_mid ? mid_evt : end_evt) |=> $stable(cmp_val));

  // R1
  carrier_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    carrier <= act_max);
endmodule

bind pwm_leg_top pwm_leg_chk #(.CNT_W(CNT_W), .DT_W(DT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .out_hi(out_hi), .out_lo(out_lo),
  .edge_evt(edge_evt), .dead_cycles(dead_cycles), .end_evt(end_evt),
  .mid_evt(mid_evt), .latch_mid(latch_mid), .act_max(act_max),
  .act_mode(act_mode), .cmp_val(cmp_val), .carrier(carrier)
);

// File: tb/sim_pwm_leg_top.sv
`timescale 1ns/1ps
module sim_pwm_leg_top;
  localparam int CW = 4;
  localparam int DW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [CW-1:0] period_max = '0;
  logic [1:0]    mode_sel = '0;
  logic [CW-1:0] duty = '0;
  logic          latch_mid = 1'b0;
  logic          trig_mid = 1'b0;
  logic [DW-1:0] dead_cycles = '0;
  logic [CW-1:0] carrier;
  logic          out_hi, out_lo, adc_start;

  int n_cmp = 0;
  int n_bad = 0;

  // model state
  int m_max, m_mode, m_pos, m_cmp, m_age, m_dload, k_duty;
  bit m_lvl;

  always #5 clk = ~clk;

  pwm_leg_top #(.CNT_W(CW), .DT_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .period_max(period_max), .mode_sel(mode_sel),
    .duty(duty), .latch_mid(latch_mid), .trig_mid(trig_mid),
    .dead_cycles(dead_cycles), .carrier(carrier), .out_hi(out_hi),
    .out_lo(out_lo), .adc_start(adc_start)
  );

  function automatic int len_of(int md, int mx);
    if (md == 2) return (mx == 0) ? 1 : 2 * mx;
    return mx + 1;
  endfunction

  function automatic int val_of(int md, int mx, int p);
    if (md == 1) return mx - p;
    if (md == 2) return (p <= mx) ? p : 2 * mx - p;
    return p;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic one_cycle(int mx, int md, bit lm, bit tm, int dt);
    int v, e_hi, e_lo;
    bit is_end, is_mid, want;
    v      = val_of(m_mode, m_max, m_pos);
    is_end = (m_pos == len_of(m_mode, m_max) - 1);
    is_mid = (m_mode == 2) ? (m_pos == m_max) : (v == (m_max / 2));
    e_hi   = (m_lvl && m_age >= m_dload) ? 1 : 0;
    e_lo   = (!m_lvl && m_age >= m_dload) ? 1 : 0;
    // R1 R2 carrier shape and boundary reload
    check(int'(carrier) == v, "R1 R2 carrier", int'(carrier), v);
    // R3 trigger position
    check(adc_start == (trig_mid ? is_mid : is_end), "R3 adc_start",
          int'(adc_start), int'(trig_mid ? is_mid : is_end));
    // R4 R5 R6 R7 primary drive
    check(int'(out_hi) == e_hi, "R4 R5 R6 R7 out_hi", int'(out_hi), e_hi);
    check(int'(out_lo) == e_lo, "R5 R6 R7 out_lo", int'(out_lo), e_lo);
    // R8 never both on
    check(!(out_hi && out_lo), "R8 overlap", int'(out_hi & out_lo), 0);
    // drive inputs for the coming edge
    period_max  = CW'(mx);
    mode_sel    = 2'(md);
    latch_mid   = lm;
    trig_mid    = tm;
    dead_cycles = DW'(dt);
    case (k_duty % 7)
      0: duty = '0;
      1: duty = '1;
      default: duty = CW'((k_duty * 5 + 3) % 16);
    endcase
    k_duty++;
    // advance model
    want = (v < m_cmp);
    if (want != m_lvl) begin
      m_lvl = want; m_age = 0; m_dload = dt;
    end else if (m_age < 1000) m_age++;
    if (lm ? is_mid : is_end) m_cmp = int'(duty);
    if (is_end) begin
      m_max = mx; m_mode = (md == 3) ? 0 : md; m_pos = 0;
    end else m_pos++;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int dts[4];
    dts[0] = 0; dts[1] = 1; dts[2] = 2; dts[3] = 5;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R9 reset state
    check(int'(carrier) == 0, "R9 carrier", int'(carrier), 0);
    check(out_hi == 1'b0, "R9 out_hi", int'(out_hi), 0);
    check(out_lo == 1'b1, "R9 out_lo", int'(out_lo), 1);
    m_max = 0; m_mode = 0; m_pos = 0; m_cmp = 0;
    m_lvl = 1'b0; m_age = 1000; m_dload = 0; k_duty = 0;
    for (int md = 0; md < 4; md++)
      for (int mx = 0; mx < 16; mx++)
        for (int sel = 0; sel < 4; sel++)
          for (int di = 0; di < 4; di++) begin
            int n;
            n = 3 * len_of((md == 3) ? 0 : md, mx) + 4;
            for (int c = 0; c < n; c++)
              one_cycle(mx, md, sel[0], sel[1], dts[di]);
          end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule